// File: doc/BRIEF.md
# Shared Reference Divider with Test Override Matrix

This block divides one reference clock through a single free-running binary counter. Two phase-detector loops each take their own comparison clock from that counter. Each loop picks its tap with a 3-bit ratio code. The two loops use code maps that are offset by one octave. A code change waits for the counter to wrap, so a new ratio never produces a short pulse.

The same block applies a 3-bit test field. The field can override the charge-pump control signals of both loops, and it can steer internal signals onto the two switching-port pins. In normal operation the pump signals pass through unchanged and the port pins follow the port bits. The test modes are:
- forced sink
- forced source
- pumps disabled while the comparison clocks are routed to the ports
- the divided RF pulses, halved, routed to the ports

All inputs are sampled on the reference clock. The block has no streaming interface. Every pin is a plain level or a pulse that is valid in each reference cycle, so no back-pressure rules apply.

Top module: `refdiv_testmux`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the counter is zero, both active ratio codes are 000 and both halving toggles are 0. Both comparison clocks therefore read 0.
- R2: Loop 1 with active code c (000 to 111) gives a comparison clock equal to bit c of the 9-bit counter. This is a 50% duty square wave with a ratio of 2, 4, 8, 16, 32, 64, 128 or 256.
- R3: Loop 2 with active code c gives a comparison clock equal to bit c+1 of the counter, a ratio of 4, 8, 16, 32, 64, 128, 256 or 512.
- R4: A new ratio code on either input is captured only at the edge where the counter wraps from 511 to 0. In every other cycle the active code is held.
- R5: When test bit 0 is 0, test bits 2 and 1 have no effect. Each pump output equals its phase-detector input. Port pin 0 equals port bit 0, and port pin 1 equals port bit 1.
- R6: Test field 001 forces both loops to sink: pump-down is 1 and pump-up is 0.
- R7: Test field 011 forces both loops to source: pump-up is 1 and pump-down is 0.
- R8: Test field 101 holds all four pump outputs at 0. It drives port pin 1 with the loop 1 comparison clock and port pin 0 with the loop 2 comparison clock.
- R9: Test field 111 passes the pump signals through unchanged. It drives port pin 1 with the loop 1 halving toggle and port pin 0 with the loop 2 halving toggle.
- R10: In test fields 001 and 011 the port pins follow the port bits, as in normal operation.
- R11: Each halving toggle inverts on every reference edge where its RF pulse input is 1, in every test mode. It is visible on the ports when the test field is 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio1_code | input | 3 | Loop 1 ratio code |
| ratio2_code | input | 3 | Loop 2 ratio code |
| test_bits | input | 3 | Test field; bit 2 is T2, bit 0 is T0 |
| pd1_up | input | 1 | Loop 1 phase-detector up |
| pd1_dn | input | 1 | Loop 1 phase-detector down |
| pd2_up | input | 1 | Loop 2 phase-detector up |
| pd2_dn | input | 1 | Loop 2 phase-detector down |
| rf1_pulse | input | 1 | Loop 1 divided RF pulse, one reference cycle wide |
| rf2_pulse | input | 1 | Loop 2 divided RF pulse, one reference cycle wide |
| port_bits | input | 2 | Port levels for normal mode; bit 0 is P0 |
| cmp1_clk | output | 1 | Loop 1 comparison clock |
| cmp2_clk | output | 1 | Loop 2 comparison clock |
| pump1_up | output | 1 | Loop 1 pump-up after override |
| pump1_dn | output | 1 | Loop 1 pump-down after override |
| pump2_up | output | 1 | Loop 2 pump-up after override |
| pump2_dn | output | 1 | Loop 2 pump-down after override |
| port_p0 | output | 1 | Switching port pin 0 |
| port_p1 | output | 1 | Switching port pin 1 |

## Verification
Two functions can act in the same cycle. The counter wrap captures new ratio codes, and in test field 101 the ports are showing the comparison clocks. A tap switch is therefore seen on the port pins in the same cycle as on the comparison outputs. The bench changes the codes part-way through a counter period while test field 101 is active. It also steps through all eight code pairs across successive wraps. In every cycle it judges the outputs against a reference counter model that moves the active code only on the wrap edge. The halving toggles keep running while other modes are active, and the bench checks the values they have reached when it switches to test field 111.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int NLOOP   = 2;
  localparam int CNT_W   = 9;
  localparam int CODE_W  = 3;
  localparam int TEST_W  = 3;

  typedef enum logic [2:0] {
    TM_NORMAL    = 3'd0,
    TM_SINK      = 3'd1,
    TM_SOURCE    = 3'd2,
    TM_SHOW_CMP  = 3'd3,
    TM_SHOW_RF   = 3'd4
  } tmode_e;

  function automatic tmode_e decode_test(input logic [TEST_W-1:0] t);
    if (!t[0])           return TM_NORMAL;
    case (t[2:1])
      2'b00:   return TM_SINK;
      2'b01:   return TM_SOURCE;
      2'b10:   return TM_SHOW_CMP;
      default: return TM_SHOW_RF;
    endcase
  endfunction
endpackage

// File: rtl/refdiv_tap.sv
module refdiv_tap #(
  parameter int CNT_W  = 9,
  parameter int CODE_W = 3,
  parameter int OFFSET = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrap,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] sel_q,
  output logic              tap_o
);
  localparam int IDX_W = $clog2(CNT_W) + 1;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] mask;

  // active code moves only when the counter wraps (all ones -> zero)
  always_ff @(posedge clk) begin
    if (!rst_n)     sel_q <= '0;
    else if (wrap)  sel_q <= code_in;
  end

  always_comb begin
    idx   = IDX_W'(sel_q) + IDX_W'(OFFSET);
    mask  = CNT_W'(1) << idx;
    tap_o = |(cnt & mask);
  end
endmodule

// File: rtl/refdiv_chain.sv
module refdiv_chain
  import refdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_in [NLOOP],
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CODE_W-1:0] sel_q   [NLOOP],
  output logic              tap_o   [NLOOP]
);
  logic wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign wrap = &cnt_q;

  // each loop's code map is shifted up one octave from the previous loop
  generate
    for (genvar g = 0; g < NLOOP; g++) begin : g_tap
      if (g + (1 << CODE_W) > CNT_W) begin : g_bad
        initial $fatal(1, "counter too narrow for tap map");
      end
      refdiv_tap #(.CNT_W(CNT_W), .CODE_W(CODE_W), .OFFSET(g)) u_tap (
        .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .wrap(wrap),
        .code_in(code_in[g]), .sel_q(sel_q[g]), .tap_o(tap_o[g])
      );
    end
  endgenerate
endmodule

// File: rtl/refdiv_pump.sv
module refdiv_pump
  import refdiv_pkg::*;
(
  input  tmode_e mode,
  input  logic   pd_up,
  input  logic   pd_dn,
  output logic   up_o,
  output logic   dn_o
);
  always_comb begin
    case (mode)
      TM_SINK:     begin up_o = 1'b0;  dn_o = 1'b1;  end
      TM_SOURCE:   begin up_o = 1'b1;  dn_o = 1'b0;  end
      TM_SHOW_CMP: begin up_o = 1'b0;  dn_o = 1'b0;  end
      default:     begin up_o = pd_up; dn_o = pd_dn; end
    endcase
  end
endmodule

// File: rtl/refdiv_portmux.sv
module refdiv_portmux
  import refdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  tmode_e mode,
  input  logic   rf_pulse  [NLOOP],
  input  logic   cmp       [NLOOP],
  input  logic   port_bits [NLOOP],
  output logic   tog_q     [NLOOP],
  output logic   port_o    [NLOOP]
);
  generate
    for (genvar i = 0; i < NLOOP; i++) begin : g_port
      // port pin i shows loop (NLOOP-1-i): pin 1 carries loop 1, pin 0 loop 2
      localparam int SRC = NLOOP - 1 - i;

      always_ff @(posedge clk) begin
        if (!rst_n)           tog_q[i] <= 1'b0;
        else if (rf_pulse[i]) tog_q[i] <= ~tog_q[i];
      end

      always_comb begin
        case (mode)
          TM_SHOW_CMP: port_o[i] = cmp[SRC];
          TM_SHOW_RF:  port_o[i] = tog_q[SRC];
          default:     port_o[i] = port_bits[i];
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/refdiv_testmux.sv
module refdiv_testmux
  import refdiv_pkg::*;
(
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] ratio1_code,
  input  logic [CODE_W-1:0] ratio2_code,
  input  logic [TEST_W-1:0] test_bits,
  input  logic              pd1_up,
  input  logic              pd1_dn,
  input  logic              pd2_up,
  input  logic              pd2_dn,
  input  logic              rf1_pulse,
  input  logic              rf2_pulse,
  input  logic [1:0]        port_bits,
  output logic              cmp1_clk,
  output logic              cmp2_clk,
  output logic              pump1_up,
  output logic              pump1_dn,
  output logic              pump2_up,
  output logic              pump2_dn,
  output logic              port_p0,
  output logic              port_p1
);
  tmode_e            mode;
  logic [CODE_W-1:0] code_w [NLOOP];
  logic [CODE_W-1:0] sel_w  [NLOOP];
  logic [CNT_W-1:0]  cnt_w;
  logic              tap_w  [NLOOP];
  logic              pdu_w  [NLOOP];
  logic              pdd_w  [NLOOP];
  logic              upo_w  [NLOOP];
  logic              dno_w  [NLOOP];
  logic              rf_w   [NLOOP];
  logic              pb_w   [NLOOP];
  logic              tog_w  [NLOOP];
  logic              prt_w  [NLOOP];

  assign mode      = decode_test(test_bits);
  assign code_w[0] = ratio1_code;
  assign code_w[1] = ratio2_code;
  assign pdu_w[0]  = pd1_up;
  assign pdu_w[1]  = pd2_up;
  assign pdd_w[0]  = pd1_dn;
  assign pdd_w[1]  = pd2_dn;
  assign rf_w[0]   = rf1_pulse;
  assign rf_w[1]   = rf2_pulse;
  assign pb_w[0]   = port_bits[0];
  assign pb_w[1]   = port_bits[1];

  refdiv_chain u_chain (
    .clk(clk_ref), .rst_n(rst_n), .code_in(code_w),
    .cnt_q(cnt_w), .sel_q(sel_w), .tap_o(tap_w)
  );

  generate
    for (genvar l = 0; l < NLOOP; l++) begin : g_pump
      refdiv_pump u_pump (
        .mode(mode), .pd_up(pdu_w[l]), .pd_dn(pdd_w[l]),
        .up_o(upo_w[l]), .dn_o(dno_w[l])
      );
    end
  endgenerate

  refdiv_portmux u_ports (
    .clk(clk_ref), .rst_n(rst_n), .mode(mode), .rf_pulse(rf_w),
    .cmp(tap_w), .port_bits(pb_w), .tog_q(tog_w), .port_o(prt_w)
  );

  assign cmp1_clk = tap_w[0];
  assign cmp2_clk = tap_w[1];
  assign pump1_up = upo_w[0];
  assign pump1_dn = dno_w[0];
  assign pump2_up = upo_w[1];
  assign pump2_dn = dno_w[1];
  assign port_p0  = prt_w[0];
  assign port_p1  = prt_w[1];
endmodule

// File: rtl/refdiv_testmux_chk.sv
module refdiv_testmux_chk (
  input logic       clk_ref,
  input logic       rst_n,
  input logic [2:0] test_bits,
  input logic [1:0] port_bits,
  input logic       pd1_up, pd1_dn, pd2_up, pd2_dn,
  input logic       rf1_pulse, rf2_pulse,
  input logic       cmp1_clk, cmp2_clk,
  input logic       pump1_up, pump1_dn, pump2_up, pump2_dn,
  input logic       port_p0, port_p1,
  input logic [8:0] cnt,
  input logic [2:0] sel1, sel2,
  input logic       tog1, tog2
);
  // R1: the first cycle after reset starts from an all-zero state
  a_r1_reset_state: assert property (@(posedge clk_ref)
    !rst_n |=> (cnt == 9'd0 && sel1 == 3'd0 && sel2 == 3'd0 && !tog1 && !tog2));
  // R2, R3: the counter advances by one on every edge
  a_r2_counter_step: assert property (@(posedge clk_ref) disable iff (!rst_n)
    rst_n |=> cnt == $past(cnt) + 9'd1);
  // R4: active codes are held except at the wrap
  a_r4_code_hold: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (cnt != 9'h1ff) |=> ($stable(sel1) && $stable(sel2)));
  a_r5_normal_pass: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !test_bits[0] |-> (pump1_up == pd1_up && pump1_dn == pd1_dn &&
                       pump2_up == pd2_up && pump2_dn == pd2_dn &&
                       port_p0 == port_bits[0] && port_p1 == port_bits[1]));
  a_r6_sink: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (test_bits == 3'b001) |-> (!pump1_up && pump1_dn && !pump2_up && pump2_dn));
  a_r7_source: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (test_bits == 3'b011) |-> (pump1_up && !pump1_dn && pump2_up && !pump2_dn));
  a_r8_show_cmp: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (test_bits == 3'b101) |-> (!pump1_up && !pump1_dn && !pump2_up && !pump2_dn &&
                               port_p1 == cmp1_clk && port_p0 == cmp2_clk));
  a_r9_show_rf: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (test_bits == 3'b111) |-> (port_p1 == tog1 && port_p0 == tog2));
  a_r11_toggle1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    rf1_pulse |=> (tog1 != $past(tog1)));
  a_r11_hold1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !rf1_pulse |=> $stable(tog1));
  a_r11_toggle2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    rf2_pulse |=> (tog2 != $past(tog2)));
endmodule

bind refdiv_testmux refdiv_testmux_chk u_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .test_bits(test_bits), .port_bits(port_bits),
  .pd1_up(pd1_up), .pd1_dn(pd1_dn), .pd2_up(pd2_up), .pd2_dn(pd2_dn),
  .rf1_pulse(rf1_pulse), .rf2_pulse(rf2_pulse),
  .cmp1_clk(cmp1_clk), .cmp2_clk(cmp2_clk),
  .pump1_up(pump1_up), .pump1_dn(pump1_dn), .pump2_up(pump2_up), .pump2_dn(pump2_dn),
  .port_p0(port_p0), .port_p1(port_p1),
  .cnt(cnt_w), .sel1(sel_w[0]), .sel2(sel_w[1]), .tog1(tog_w[0]), .tog2(tog_w[1])
);

// File: tb/refdiv_testmux_test.sv
module refdiv_testmux_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [2:0] r1, r2, tb;
  logic       u1, d1, u2, d2, rf1, rf2;
  logic [1:0] pb;
  logic       c1_o, c2_o, u1_o, d1_o, u2_o, d2_o, p0_o, p1_o;

  refdiv_testmux uut (
    .clk_ref(clk), .rst_n(rst_n), .ratio1_code(r1), .ratio2_code(r2),
    .test_bits(tb), .pd1_up(u1), .pd1_dn(d1), .pd2_up(u2), .pd2_dn(d2),
    .rf1_pulse(rf1), .rf2_pulse(rf2), .port_bits(pb),
    .cmp1_clk(c1_o), .cmp2_clk(c2_o), .pump1_up(u1_o), .pump1_dn(d1_o),
    .pump2_up(u2_o), .pump2_dn(d2_o), .port_p0(p0_o), .port_p1(p1_o)
  );

  typedef struct {
    logic       c1, c2;
    logic [3:0] pmp;   // {up1, dn1, up2, dn2}
    logic [1:0] prt;   // {p1, p0}
    logic [2:0] tm;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  logic done = 1'b0;

  int         mcnt;
  logic [2:0] msel1, msel2, s_r1, s_r2, s_tb;
  logic       mt1, mt2;
  logic [15:0] lfsr = 16'hACE1;

  function automatic string pump_tag(input logic [2:0] t);
    if (!t[0])         return "R5";
    if (t == 3'b001)   return "R6";
    if (t == 3'b011)   return "R7";
    if (t == 3'b101)   return "R8";
    return "R9";
  endfunction

  function automatic string port_tag(input logic [2:0] t);
    if (!t[0])         return "R5";
    if (t == 3'b101)   return "R8";
    if (t == 3'b111)   return "R9,R11";
    return "R10";
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // driver: advance the reference model, apply the next stimulus, push the expectation
  task automatic cycle();
    exp_t e;
    @(posedge clk);
    #1;
    mt1 = mt1 ^ rf1;
    mt2 = mt2 ^ rf2;
    if (mcnt == 511) begin msel1 = r1; msel2 = r2; end
    mcnt = (mcnt + 1) % 512;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    r1 = s_r1; r2 = s_r2; tb = s_tb;
    u1 = lfsr[0]; d1 = lfsr[1]; u2 = lfsr[2]; d2 = lfsr[3];
    rf1 = lfsr[4] & lfsr[7]; rf2 = lfsr[5] | lfsr[11];
    pb = lfsr[9:8];
    e.c1 = (mcnt >> msel1) & 1;
    e.c2 = (mcnt >> (msel2 + 1)) & 1;
    e.tm = tb;
    if (!tb[0] || tb == 3'b111) e.pmp = {u1, d1, u2, d2};
    else if (tb == 3'b001)      e.pmp = 4'b0101;
    else if (tb == 3'b011)      e.pmp = 4'b1010;
    else                        e.pmp = 4'b0000;
    if (tb == 3'b101)           e.prt = {e.c1, e.c2};
    else if (tb == 3'b111)      e.prt = {mt1, mt2};
    else                        e.prt = pb;
    q.push_back(e);
  endtask

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check_bit("R2/R4 cmp1", c1_o, e.c1);
      check_bit("R3/R4 cmp2", c2_o, e.c2);
      check_bit({pump_tag(e.tm), " pumps"}, ({u1_o, d1_o, u2_o, d2_o} == e.pmp), 1'b1);
      if ({u1_o, d1_o, u2_o, d2_o} != e.pmp)
        $display("  pumps actual=%b expected=%b", {u1_o, d1_o, u2_o, d2_o}, e.pmp);
      check_bit({port_tag(e.tm), " p1"}, p1_o, e.prt[1]);
      check_bit({port_tag(e.tm), " p0"}, p0_o, e.prt[0]);
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; r1 = 0; r2 = 0; tb = 0;
    u1 = 0; d1 = 0; u2 = 0; d2 = 0; rf1 = 0; rf2 = 0; pb = 0;
    s_r1 = 0; s_r2 = 0; s_tb = 0;
    mcnt = 0; msel1 = 0; msel2 = 0; mt1 = 0; mt2 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state visible on the outputs
    check_bit("R1 cmp1", c1_o, 1'b0);
    check_bit("R1 cmp2", c2_o, 1'b0);
    check_bit("R1 p0", p0_o, 1'b0);
    #1 rst_n = 1'b1;

    repeat (600) cycle();
    // R4: codes change mid-period, with test field 101 showing the clocks on the ports
    s_tb = 3'b101; s_r1 = 3'd3; s_r2 = 3'd5;
    repeat (700) cycle();
    s_tb = 3'b000;
    for (int k = 0; k < 8; k++) begin
      s_r1 = 3'(k); s_r2 = 3'(7 - k);
      repeat (520) cycle();
    end
    s_r1 = 3'd1; s_r2 = 3'd0;
    for (int t = 0; t < 8; t++) begin
      s_tb = 3'(t);
      repeat (260) cycle();
    end
    s_tb = 3'b111;
    repeat (300) cycle();
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule